// File: doc/BRIEF.md
# Failure-Based Capacity Grading Unit

This block sits behind a memory tester's compare logic and watches the stream of failing-address reports. From those reports it decides how much of the device under test is still usable. The answer is a contiguous, power-of-two-sized slice of the address space with no failure inside it: the whole device, a half, a quarter, and so on down to a minimum slice size. The block also reports which high-order address bits must be tied, and to what value, so that a system using the part only ever reaches that slice.

A record is built up by pulsing `fail_vld` with the failing address, one report per cycle. For every subdivision level the unit keeps one dirty flag per slice. A `clr` pulse empties the record in one cycle. A `fin` pulse grades the device. The grade prefers the largest clean slice and, among clean slices of equal size, the one with the lowest index. The result appears one cycle later and is held until the next grading.

Top module: `capacity_grader`

## Requirements
- R1: While and after reset, `res_vld` is 0, `grade` is 0 and both `force_mask` and `force_val` are all zeros.
- R2: `res_vld` is 1 in exactly the cycle after a cycle in which `fin` is 1. `grade`, `force_mask` and `force_val` change only in that cycle and otherwise hold their value.
- R3: With no failure recorded, grading gives `grade` = 0 (full capacity) with `force_mask` and `force_val` all zeros.
- R4: When every recorded failure has the top address bit set, grading gives `grade` = 1 (half). `force_mask` has only its MSB set, which stands for address bit ADDR_W-1, and `force_val` is all zeros, so the top bit is forced to 0.
- R5: When every recorded failure has the top address bit clear, grading gives `grade` = 1, `force_mask` MSB set and `force_val` MSB set, so the top bit is forced to 1.
- R6: Otherwise the grade is the smallest level k (1 ≤ k ≤ NLVL) at which some slice of size 2^(ADDR_W-k) holds no failure. Among clean slices at that level the lowest index j (j = the top k address bits) wins. `force_mask` then has its top k bits set, `force_val` carries j in those top k bits and zeros below them, and $countones(`force_mask`) equals `grade`.
- R7: If every slice at the deepest level NLVL holds a failure, `grade` = NLVL+1 (reject) and `force_mask` and `force_val` are all zeros.
- R8: A `clr` pulse empties the record by the next cycle. A failure reported in the same cycle as `clr` is dropped.
- R9: A failure reported in the same cycle as `fin` counts toward that grading.
- R10: A `fin` in the same cycle as `clr` grades an empty record and gives full capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Empty the failure record |
| fin | input | 1 | Grade the device from the record |
| fail_vld | input | 1 | A failing address is presented |
| fail_addr | input | ADDR_W | Failing address |
| res_vld | output | 1 | One-cycle pulse: grade just updated |
| grade | output | clog2(NLVL+2) | 0 full, k means 1/2^k, NLVL+1 reject |
| force_mask | output | NLVL | High-order address bits to force (MSB = top address bit) |
| force_val | output | NLVL | Values for the forced bits |

## Verification
Three pairs of controls can land in the same cycle: a failure report together with `fin`, a failure report together with `clr`, and `clr` together with `fin`. The bench drives each pair on the same clock edge. It judges the result against a queue-based model that handles each pair by the stated priority: a failure arriving with `fin` is graded, a failure arriving with `clr` is discarded, and `fin` with `clr` sees an empty record. In the cycle after each such collision the outputs are compared with hand-worked grades.

// File: rtl/cgrade_pkg.sv
package cgrade_pkg;

    // Total number of slice flags across levels 0..nlvl
    function automatic int flag_total(input int nlvl);
        return (2 << nlvl) - 1;
    endfunction

    // First flag position of a given level in the flat flag vector
    function automatic int lvl_base(input int lvl);
        return (1 << lvl) - 1;
    endfunction

    // Slice index of an address at a level: its top lvl bits
    function automatic int slice_of(input logic [31:0] addr, input int aw, input int lvl);
        if (lvl == 0) return 0;
        return int'(addr >> (aw - lvl));
    endfunction

endpackage

// File: rtl/cg_flag_bank.sv
module cg_flag_bank #(
    parameter int ADDR_W = 8,
    parameter int NLVL   = 3,
    localparam int NFLAG = cgrade_pkg::flag_total(NLVL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              fail_vld,
    input  logic [ADDR_W-1:0] fail_addr,
    output logic [NFLAG-1:0]  flags_q,
    output logic [NFLAG-1:0]  flags_nxt
);
    import cgrade_pkg::*;

    localparam int NFINE = 1 << NLVL;

    logic [31:0] addr_ext;
    assign addr_ext = {{(32-ADDR_W){1'b0}}, fail_addr};

    for (genvar lv = 0; lv <= NLVL; lv++) begin : g_lvl
        localparam int BASE = (1 << lv) - 1;
        for (genvar j = 0; j < (1 << lv); j++) begin : g_slice
            logic hit;
            assign hit = fail_vld && (slice_of(addr_ext, ADDR_W, lv) == j);
            assign flags_nxt[BASE+j] = clr ? 1'b0 : (flags_q[BASE+j] | hit);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= flags_nxt;
    end

    // R8
    clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (flags_q == '0));

    // R6
    lvl_agree_chk: assert property (@(posedge clk) disable iff (rst)
        flags_q[0] == (|flags_q[NFLAG-1 -: NFINE]));

endmodule

// File: rtl/cg_grade_pick.sv
module cg_grade_pick #(
    parameter int NLVL = 3,
    localparam int NFLAG = cgrade_pkg::flag_total(NLVL),
    localparam int GW    = $clog2(NLVL + 2)
) (
    input  logic [NFLAG-1:0] flags,
    output logic [GW-1:0]    grade,
    output logic [NLVL-1:0]  fmask,
    output logic [NLVL-1:0]  fval
);
    import cgrade_pkg::*;

    always_comb begin
        logic found;
        found = 1'b0;
        grade = GW'(NLVL + 1);
        fmask = '0;
        fval  = '0;
        for (int lv = 0; lv <= NLVL; lv++) begin
            for (int j = 0; j < (1 << lv); j++) begin
                if (!found && !flags[lvl_base(lv) + j]) begin
                    found = 1'b1;
                    grade = GW'(lv);
                    fmask = NLVL'(((1 << lv) - 1) << (NLVL - lv));
                    fval  = NLVL'(j << (NLVL - lv));
                end
            end
        end
    end

endmodule

// File: rtl/capacity_grader.sv
module capacity_grader #(
    parameter int ADDR_W = 8,
    parameter int NLVL   = 3,
    localparam int NFLAG = cgrade_pkg::flag_total(NLVL),
    localparam int GW    = $clog2(NLVL + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              fin,
    input  logic              fail_vld,
    input  logic [ADDR_W-1:0] fail_addr,
    output logic              res_vld,
    output logic [GW-1:0]     grade,
    output logic [NLVL-1:0]   force_mask,
    output logic [NLVL-1:0]   force_val
);
    typedef struct packed {
        logic [GW-1:0]   grade;
        logic [NLVL-1:0] mask;
        logic [NLVL-1:0] val;
    } verdict_t;

    localparam logic [GW-1:0] REJ = GW'(NLVL + 1);

    logic [NFLAG-1:0] flags_q;
    logic [NFLAG-1:0] flags_nxt;
    verdict_t         pick;
    verdict_t         res_q;
    logic             vld_q;

    cg_flag_bank #(.ADDR_W(ADDR_W), .NLVL(NLVL)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .fail_vld  (fail_vld),
        .fail_addr (fail_addr),
        .flags_q   (flags_q),
        .flags_nxt (flags_nxt)
    );

    // Grades the state the record will hold after this edge, so a
    // coincident failure or clear is already accounted for.
    cg_grade_pick #(.NLVL(NLVL)) u_pick (
        .flags (flags_nxt),
        .grade (pick.grade),
        .fmask (pick.mask),
        .fval  (pick.val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= fin;
            if (fin) res_q <= pick;
        end
    end

    assign res_vld    = vld_q;
    assign grade      = res_q.grade;
    assign force_mask = res_q.mask;
    assign force_val  = res_q.val;

    // R2
    vld_follows_fin_chk: assert property (@(posedge clk) disable iff (rst)
        fin |=> res_vld);

    // R2
    vld_only_after_fin_chk: assert property (@(posedge clk) disable iff (rst)
        !fin |=> !res_vld);

    // R2
    verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fin |=> ($stable(grade) && $stable(force_mask) && $stable(force_val)));

    // R3
    full_unforced_chk: assert property (@(posedge clk) disable iff (rst)
        (grade == '0) |-> (force_mask == '0));

    // R6
    mask_width_chk: assert property (@(posedge clk) disable iff (rst)
        (grade != REJ) |-> ($countones(force_mask) == int'(grade)));

    // R6
    val_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (force_val & ~force_mask) == '0);

    // R7
    reject_unforced_chk: assert property (@(posedge clk) disable iff (rst)
        (grade == REJ) |-> (force_mask == '0 && force_val == '0));

endmodule

// File: tb/capacity_grader_tb.sv
module capacity_grader_tb;
    localparam int CLK_P  = 10;
    localparam int ADDR_W = 8;
    localparam int NLVL   = 3;
    localparam int GW     = $clog2(NLVL + 2);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              clr = 1'b0;
    logic              fin = 1'b0;
    logic              fail_vld = 1'b0;
    logic [ADDR_W-1:0] fail_addr = '0;
    logic              res_vld;
    logic [GW-1:0]     grade;
    logic [NLVL-1:0]   force_mask;
    logic [NLVL-1:0]   force_val;

    int n_cmp = 0;
    int n_bad = 0;
    string cur_req = "R1";

    // reference model state
    int fails[$];
    int exp_vld = 0, exp_g = 0, exp_m = 0, exp_v = 0;

    capacity_grader #(.ADDR_W(ADDR_W), .NLVL(NLVL)) u_dut (
        .clk(clk), .rst(rst), .clr(clr), .fin(fin),
        .fail_vld(fail_vld), .fail_addr(fail_addr),
        .res_vld(res_vld), .grade(grade),
        .force_mask(force_mask), .force_val(force_val)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic ref_grade(output int g, output int m, output int v);
        g = NLVL + 1; m = 0; v = 0;
        for (int lv = 0; lv <= NLVL; lv++) begin
            for (int j = 0; j < (1 << lv); j++) begin
                bit dirty = 0;
                foreach (fails[i]) begin
                    int s = (lv == 0) ? 0 : (fails[i] >> (ADDR_W - lv));
                    if (s == j) dirty = 1;
                end
                if (!dirty && g == NLVL + 1) begin
                    g = lv;
                    m = ((1 << lv) - 1) << (NLVL - lv);
                    v = j << (NLVL - lv);
                end
            end
        end
    endtask

    // model update at each edge, compare a quarter period later
    always begin
        @(posedge clk);
        if (rst) begin
            fails.delete();
            exp_vld = 0; exp_g = 0; exp_m = 0; exp_v = 0;
        end else begin
            int g, m, v;
            if (clr) fails.delete();
            else if (fail_vld) fails.push_back(int'(fail_addr));
            exp_vld = fin ? 1 : 0;
            if (fin) begin
                ref_grade(g, m, v);
                exp_g = g; exp_m = m; exp_v = v;
            end
        end
        #(CLK_P/4);
        n_cmp++;
        if (int'(res_vld) != exp_vld || int'(grade) != exp_g ||
            int'(force_mask) != exp_m || int'(force_val) != exp_v) begin
            n_bad++;
            $display("FAIL %s model: vld=%0d g=%0d m=%0h v=%0h expected vld=%0d g=%0d m=%0h v=%0h",
                     cur_req, res_vld, grade, force_mask, force_val, exp_vld, exp_g, exp_m, exp_v);
        end
    end

    task automatic drive(input bit fv, input int a, input bit c, input bit f);
        @(negedge clk);
        fail_vld  = fv;
        fail_addr = ADDR_W'(a);
        clr       = c;
        fin       = f;
    endtask

    task automatic idle();
        drive(0, 0, 0, 0);
    endtask

    // finalize, then check the hand-worked verdict in the following cycle
    task automatic grade_check(input string req, input int g, input int m, input int v);
        cur_req = req;
        drive(0, 0, 0, 1);
        idle();
        n_cmp++;
        if (res_vld !== 1'b1 || int'(grade) != g || int'(force_mask) != m || int'(force_val) != v) begin
            n_bad++;
            $display("FAIL %s: vld=%0d g=%0d m=%0h v=%0h expected vld=1 g=%0d m=%0h v=%0h",
                     req, res_vld, grade, force_mask, force_val, g, m, v);
        end
    endtask

    task automatic clear_rec();
        drive(0, 0, 1, 0);
        idle();
    endtask

    task automatic report(input int a);
        drive(1, a, 0, 0);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        n_cmp++;
        if (res_vld !== 1'b0 || grade !== '0 || force_mask !== '0 || force_val !== '0) begin
            n_bad++;
            $display("FAIL R1: vld=%0d g=%0d m=%0h v=%0h expected all 0",
                     res_vld, grade, force_mask, force_val);
        end
        rst = 1'b0;
        repeat (2) idle();

        // R3 empty record
        grade_check("R3", 0, 0, 0);

        // R4 failures in upper half only
        report('hC5); report('h80);
        grade_check("R4", 1, 3'b100, 3'b000);

        // R2 outputs hold across idle cycles
        cur_req = "R2";
        repeat (4) idle();

        // R5 failures in lower half only
        clear_rec();
        report('h12); report('h7F);
        grade_check("R5", 1, 3'b100, 3'b100);

        // R6 quarter: slices 0 and 2 dirty, slice 1 clean
        clear_rec();
        report('h12); report('h85);
        grade_check("R6", 2, 3'b110, 3'b010);

        // R6 eighth: every quarter dirty, eighth 1 clean
        clear_rec();
        report('h00); report('h40); report('h80); report('hC0);
        grade_check("R6", 3, 3'b111, 3'b001);

        // R6 lowest index preferred: only eighth 5 clean
        clear_rec();
        for (int k = 0; k < 8; k++) if (k != 5) report(k << 5);
        grade_check("R6", 3, 3'b111, 3'b101);

        // R7 reject: every eighth dirty
        report('hA3);
        grade_check("R7", NLVL + 1, 0, 0);

        // R8 clear empties record
        clear_rec();
        grade_check("R8", 0, 0, 0);

        // R9 failure coincident with fin is graded
        cur_req = "R9";
        drive(1, 'hF0, 0, 1);
        idle();
        n_cmp++;
        if (int'(grade) != 1 || force_mask != 3'b100 || force_val != 3'b000) begin
            n_bad++;
            $display("FAIL R9: g=%0d m=%0h v=%0h expected g=1 m=4 v=0", grade, force_mask, force_val);
        end

        // R8 failure coincident with clr is dropped
        cur_req = "R8";
        drive(1, 'h33, 1, 0);
        idle();
        grade_check("R8", 0, 0, 0);

        // R10 fin with clr on a dirty record
        report('h10); report('hE0);
        cur_req = "R10";
        drive(1, 'h55, 1, 1);
        idle();
        n_cmp++;
        if (res_vld !== 1'b1 || grade !== '0 || force_mask !== '0 || force_val !== '0) begin
            n_bad++;
            $display("FAIL R10: vld=%0d g=%0d m=%0h v=%0h expected vld=1 all 0",
                     res_vld, grade, force_mask, force_val);
        end
        grade_check("R10", 0, 0, 0);

        // mixed traffic, judged by the model every cycle (R2 R6 R8 R9)
        cur_req = "R6";
        for (int t = 0; t < 400; t++) begin
            int r = int'($urandom_range(0, 99));
            drive(r < 40, int'($urandom_range(0, 255)), r >= 95, (r % 7) == 0);
        end
        repeat (3) idle();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule